// File: doc/BRIEF.md
# Packet-Commit Synchronous FIFO

This block is a single-clock FIFO for packetised traffic. The writer pushes the words of a packet one by one and flags the final word with a commit strobe. Until that strobe arrives, the words are stored but stay invisible to the reader. The reader's empty flag, almost-empty flag, packet-available indication and read data all follow a committed write pointer. That pointer jumps forward only when a packet closes. A consumer can therefore wait for `pktAvail` and then drain a whole packet without stalling in the middle of it.

Capacity is judged against the live write pointer. The writer's full and almost-full flags therefore count committed words and words still pending commit. Both thresholds are run-time inputs. The depth is a power of two, 2^ADDR_W, and all pointers wrap by plain modulo arithmetic. Read data falls through: `rdData` shows the oldest visible word whenever `empty` is low.

Top module: `pktfifo_commit`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty`=1, `almostEmpty`=1, `pktAvail`=0, `full`=0 and `almostFull`=0.
- R2: Words written without a commit leave `empty`=1 and `pktAvail`=0 as long as no earlier packet is still unread.
- R3: A write accepted with `wrCommit`=1 makes all words written so far visible from the next cycle (`empty`=0, `pktAvail`=1). `rdData` then presents them in write order, one word per accepted read.
- R4: `full` rises in the cycle after an accepted write brings the stored word count, committed or not, to 2^ADDR_W. It falls in the cycle after an accepted read. A simultaneous accepted read and write leaves it low.
- R5: A write request while `full`=1 stores nothing and moves no pointer.
- R6: `empty` rises in the cycle after the last visible word is read. A read request while `empty`=1 moves no pointer and consumes nothing.
- R7: `almostFull` is 1 exactly when at least one word is stored (committed or not) and the free slot count (2^ADDR_W minus stored) is at most `afThresh`.
- R8: `almostEmpty` is 1 exactly when the visible word count is below 2^ADDR_W and at most `aeThresh`.
- R9: A commit on a write that is refused because the FIFO is full has no effect on what the reader sees.
- R10: An accepted read and an accepted commit write in the same cycle both take effect, and `empty` stays 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| wrData | input | DATA_W | Word to store |
| wrReq | input | 1 | Write request |
| wrCommit | input | 1 | Marks the current write as the last word of a packet |
| afThresh | input | ADDR_W | Free-slot threshold for almostFull |
| full | output | 1 | No free slot left |
| almostFull | output | 1 | Free slots at or below threshold |
| rdReq | input | 1 | Read request, consumes the word on rdData |
| aeThresh | input | ADDR_W | Visible-word threshold for almostEmpty |
| rdData | output | DATA_W | Oldest visible word |
| empty | output | 1 | No committed word available |
| almostEmpty | output | 1 | Visible words at or below threshold |
| pktAvail | output | 1 | At least one committed word is waiting |

## Verification
A committed pointer that slips ahead of the writer shows up on the very next cycle. `pktAvail` rises before any commit has been made, or `rdData` presents a word from an unfinished packet. A read or write pointer that moves on a refused request leaves the flags right for a while but shifts the data stream. It appears as a wrong word on `rdData` at the next read of the affected slot. A corrupted full or empty flag is visible in the cycle after the offending access. Once the pointers are out of step with each other, the almost flags disagree with the word count at the next threshold crossing.

// File: rtl/pktfifo_pkg.sv
package pktfifo_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
  } dpStrobe_t;
endpackage

// File: rtl/pktfifo_ctrl.sv
module pktfifo_ctrl
  import pktfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrReq,
  input  logic              wrCommit,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] afThresh,
  input  logic [ADDR_W-1:0] aeThresh,
  output logic              full,
  output logic              almostFull,
  output logic              empty,
  output logic              almostEmpty,
  output logic              pktAvail,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output dpStrobe_t         strb
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] wrPtr, cmtPtr, rdPtr;
  logic [ADDR_W-1:0] wrNext, rdNext;
  logic [ADDR_W-1:0] freeDiff, visDiff;
  logic fullQ, emptyQ;
  logic wrAcc, rdAcc, cmtAcc;
  logic liveEmpty, visFull;

  // R5, R6: requests against a full or empty FIFO are refused
  assign wrAcc  = wrReq & ~fullQ;
  assign rdAcc  = rdReq & ~emptyQ;
  // R9: a commit counts only together with an accepted write
  assign cmtAcc = wrAcc & wrCommit;
  assign wrNext = wrPtr + ONE;
  assign rdNext = rdPtr + ONE;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wrPtr  <= '0;
      cmtPtr <= '0;
      rdPtr  <= '0;
      fullQ  <= 1'b0;
      emptyQ <= 1'b1;
    end else begin
      if (wrAcc)  wrPtr  <= wrNext;
      if (cmtAcc) cmtPtr <= wrNext;   // R3: publish the whole packet
      if (rdAcc)  rdPtr  <= rdNext;
      // R4: full tracks the live pointer against the read pointer
      if (rdAcc)                          fullQ <= 1'b0;
      else if (wrAcc && wrNext == rdPtr)  fullQ <= 1'b1;
      // R6, R10: empty tracks the committed pointer
      if (cmtAcc)                         emptyQ <= 1'b0;
      else if (rdAcc && rdNext == cmtPtr) emptyQ <= 1'b1;
    end
  end

  // R7: free slots from live pointer; R8: visible words from committed pointer
  assign freeDiff    = rdPtr - wrPtr;
  assign visDiff     = cmtPtr - rdPtr;
  assign liveEmpty   = (wrPtr == rdPtr) & ~fullQ;
  assign visFull     = (cmtPtr == rdPtr) & ~emptyQ;
  assign almostFull  = (freeDiff <= afThresh) & ~liveEmpty;
  assign almostEmpty = (visDiff <= aeThresh) & ~visFull;

  assign full      = fullQ;
  assign empty     = emptyQ;
  assign pktAvail  = ~emptyQ;
  assign wrAddr    = wrPtr;
  assign rdAddr    = rdPtr;
  assign strb.wrEn = wrAcc;
endmodule

// File: rtl/pktfifo_dp.sv
module pktfifo_dp
  import pktfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.wrEn && wrAddr == ADDR_W'(i)) store[i] <= wrData;
    end
  end

  // Fall-through read of the oldest visible word
  assign rdData = store[rdAddr];
endmodule

// File: rtl/pktfifo_commit.sv
module pktfifo_commit
  import pktfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrReq,
  input  logic              wrCommit,
  input  logic [ADDR_W-1:0] afThresh,
  output logic              full,
  output logic              almostFull,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] aeThresh,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostEmpty,
  output logic              pktAvail
);
  dpStrobe_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  pktfifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrReq(wrReq), .wrCommit(wrCommit), .rdReq(rdReq),
    .afThresh(afThresh), .aeThresh(aeThresh), .full(full),
    .almostFull(almostFull), .empty(empty), .almostEmpty(almostEmpty),
    .pktAvail(pktAvail), .wrAddr(wrAddr), .rdAddr(rdAddr), .strb(strb)
  );

  pktfifo_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/pktfifo_chk.sv
module pktfifo_chk (
  input logic clk,
  input logic rst,
  input logic wrReq,
  input logic wrCommit,
  input logic rdReq,
  input logic full,
  input logic empty,
  input logic almostEmpty,
  input logic pktAvail
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (empty && almostEmpty && !full && !pktAvail));

  a_r3_commit_visible: assert property (@(posedge clk) disable iff (rst)
    (wrReq && wrCommit && !full) |=> (!empty && pktAvail));

  a_r2_hidden_until_commit: assert property (@(posedge clk) disable iff (rst)
    (empty && !(wrReq && wrCommit && !full)) |=> (empty && !pktAvail));

  a_r4_full_clears: assert property (@(posedge clk) disable iff (rst)
    (full && rdReq && !empty) |=> !full);

  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && !(rdReq && !empty)) |=> full);

  a_r10_read_and_commit: assert property (@(posedge clk) disable iff (rst)
    (rdReq && !empty && wrReq && wrCommit && !full) |=> !empty);

  a_r8_empty_is_almost_empty: assert property (@(posedge clk) disable iff (rst)
    empty |-> almostEmpty);
endmodule

bind pktfifo_commit pktfifo_chk u_chk (
  .clk(clk), .rst(rst), .wrReq(wrReq), .wrCommit(wrCommit), .rdReq(rdReq),
  .full(full), .empty(empty), .almostEmpty(almostEmpty), .pktAvail(pktAvail)
);

// File: tb/sim_pktfifo_commit.sv
`timescale 1ns/100ps
module sim_pktfifo_commit;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] wrData = '0;
  logic wrReq = 1'b0, wrCommit = 1'b0, rdReq = 1'b0;
  logic [ADDR_W-1:0] afThresh = 3, aeThresh = 2;
  logic full, almostFull, empty, almostEmpty, pktAvail;
  logic [DATA_W-1:0] rdData;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // Reference model
  logic [DATA_W-1:0] mq [256];
  int qHead = 0, qTail = 0, liveCnt = 0, visCnt = 0;
  logic [DATA_W-1:0] seq = 8'h10;

  always #2.5 clk = ~clk;

  pktfifo_commit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .wrData(wrData), .wrReq(wrReq), .wrCommit(wrCommit),
    .afThresh(afThresh), .full(full), .almostFull(almostFull), .rdReq(rdReq),
    .aeThresh(aeThresh), .rdData(rdData), .empty(empty),
    .almostEmpty(almostEmpty), .pktAvail(pktAvail)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkFlags();
    logic expAf, expAe;
    expAf = (liveCnt > 0) && ((DEPTH - liveCnt) <= int'(afThresh));
    expAe = (visCnt < DEPTH) && (visCnt <= int'(aeThresh));
    chk("R4 full", int'(full), int'(liveCnt == DEPTH));
    chk("R6 empty", int'(empty), int'(visCnt == 0));
    chk("R2/R3 pktAvail", int'(pktAvail), int'(visCnt > 0));
    chk("R7 almostFull", int'(almostFull), int'(expAf));
    chk("R8 almostEmpty", int'(almostEmpty), int'(expAe));
  endtask

  // One clock of stimulus, model update and flag check
  task automatic step(bit wr, bit cmt, bit rd);
    bit wrAcc, rdAcc;
    @(negedge clk);
    wrReq = wr; wrCommit = cmt; rdReq = rd; wrData = seq;
    #0.1;
    wrAcc = wr && (liveCnt < DEPTH);
    rdAcc = rd && (visCnt > 0);
    if (rdAcc) chk("R3 rdData order", int'(rdData), int'(mq[qHead]));
    @(posedge clk);
    #0.5;
    if (rdAcc) begin qHead = (qHead + 1) & 255; liveCnt--; visCnt--; end
    if (wrAcc) begin
      mq[qTail] = seq; qTail = (qTail + 1) & 255; liveCnt++; seq++;
      if (cmt) visCnt = liveCnt;
    end
    chkFlags();
    @(negedge clk);
    wrReq = 0; wrCommit = 0; rdReq = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(posedge clk);
    #0.5;
    chk("R1 empty", int'(empty), 1);
    chk("R1 almostEmpty", int'(almostEmpty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 almostFull", int'(almostFull), 0);
    chk("R1 pktAvail", int'(pktAvail), 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #0.5;
    chkFlags();
  endtask

  task automatic t_hidden();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    chk("R2 hidden partial", int'(pktAvail), 0);
    step(0, 0, 1);                          // read on empty ignored
    chk("R6 read on empty", int'(empty), 1);
    step(1, 1, 0);                          // commit with 4th word
    chk("R3 visible after commit", int'(pktAvail), 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    chk("R6 empty after drain", int'(empty), 1);
  endtask

  task automatic t_fill();
    afThresh = 3;
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0);
    step(1, 1, 0);
    chk("R4 full at depth", int'(full), 1);
    step(1, 1, 0);                          // refused write with commit
    chk("R5 write while full", int'(full), 1);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1);
    chk("R9 refused commit", int'(empty), 1);
  endtask

  task automatic t_simul();
    step(1, 0, 0);
    step(1, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 1);
    chk("R10 read+commit", int'(empty), 0);
    step(1, 0, 1);
    step(1, 0, 1);
    step(0, 0, 1);
    chk("R2 partial after drain", int'(pktAvail), 0);
    step(1, 1, 0);
    while (visCnt > 0) step(0, 0, 1);
  endtask

  task automatic t_thresholds();
    aeThresh = 5; afThresh = 6;
    for (int p = 1; p <= 4; p++) begin
      for (int i = 1; i < p; i++) step(1, 0, 0);
      step(1, 1, 0);
    end
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    aeThresh = 0; afThresh = 0;
    step(0, 0, 0);
    while (visCnt > 0) step(0, 0, 1);
    step(1, 1, 0);
    step(0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_hidden();
    t_fill();
    t_simul();
    t_thresholds();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule